// File: doc/BRIEF.md
# Clock-Manager Lock Supervisor Reset Generator

This block keeps a clock-management unit (a PLL or DLL-style frequency synthesizer) in a usable state when its input clock comes from an external PHY. That clock can stop, for example when no cable is plugged in, and the unit then loses lock. The supervisor runs on a separate reference clock that never stops, nominally 125 MHz. It watches the unit's lock flag and drives the unit's reset input.

Lock loss is detected as a falling edge of the synchronized lock flag and starts a long reset pulse. After any pulse the block waits for lock. If lock does not come back within a timeout, it issues another pulse. This repeats until the unit locks again.

Both lengths are parameters given in reference-clock cycles. The defaults are 200 ms of pulse and about 1.05 ms of timeout at 125 MHz. A simulation can override them with short values.

Top module: `lock_supervisor`

## Requirements
- R1: `sys_rst` is a synchronous, active-high reset. `cm_reset` is high from the first clock edge at which `sys_rst` is sampled high. It stays high for PULSE_CYCLES cycles, counted from the last edge at which `sys_rst` is sampled high.
- R2: A `sys_rst` that is sampled high during a running pulse restarts the full PULSE_CYCLES length from that edge.
- R3: `cm_locked` passes through a SYNC_STAGES-flop synchronizer (default 2). In the locked state, a high-to-low change of `cm_locked` makes `cm_reset` high at the third rising edge after the change. `cm_reset` is still low after the first two of those edges.
- R4: Every pulse started by lock loss or by timeout keeps `cm_reset` high for exactly PULSE_CYCLES cycles.
- R5: After a pulse ends, if the synchronized lock stays low, `cm_reset` stays low for exactly TIMEOUT_CYCLES cycles and then a new pulse starts.
- R6: When the synchronized lock is high while waiting, the block enters the locked state. `cm_reset` then stays low for as long as lock stays high, with no timeout retry.
- R7: Changes of `cm_locked` during a pulse, including a fall, neither shorten nor restart that pulse.
- R8: The expiry cycle of the timeout is the last cycle in which lock counts. If the synchronized lock is high in that cycle, no pulse is issued. If it becomes high only one cycle later, the retry pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| cm_locked | input | 1 | Lock flag of the supervised unit, asynchronous |
| cm_reset | output | 1 | Registered reset to the supervised unit, active high |

## Verification
Two functions can act in the same cycle: the timeout expiring in the wait state, and the synchronized lock arriving. The bench measures the cycle at which `cm_reset` falls. It then raises `cm_locked` so that the synchronized level turns high exactly in the expiry cycle, and expects no new pulse. It repeats the scenario with lock arriving one cycle later, and expects a retry after exactly TIMEOUT_CYCLES low cycles. A second overlap is a system reset landing in the middle of a running pulse; it is judged by the total length of that high run.

// File: rtl/lksup_pkg.sv
package lksup_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_PULSE  = 2'd1,
    ST_WAIT   = 2'd2
  } sup_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lksup_sync.sv
module lksup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fell
);

  logic [STAGES-1:0] chain;
  logic              level_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fell  = level_d & ~chain[STAGES-1];

  // R3: a detected fall follows a high level in the previous cycle
  a_r3_fall_after_high: assert property (@(posedge clk) disable iff (rst)
    fell |-> $past(level));

endmodule

// File: rtl/lksup_timer.sv
module lksup_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int unsigned W = lksup_pkg::cnt_width(CYCLES);
  localparam logic [W-1:0] LOAD_V = W'(CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)             cnt <= LOAD_V;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4/R5: a running count steps down by one per cycle
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (!load && run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R4: a load always restarts at the full length
  a_r4_load_full: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOAD_V));

endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor #(
  parameter int unsigned PULSE_CYCLES   = 25_000_000,
  parameter int unsigned TIMEOUT_CYCLES = 131_072,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_ref,
  input  logic sys_rst,
  input  logic cm_locked,
  output logic cm_reset
);

  import lksup_pkg::*;

  sup_state_t state;
  logic       lock_lvl;
  logic       lock_fell;
  logic       pulse_done;
  logic       wait_done;
  logic       pulse_load;
  logic       wait_load;
  logic       rst_q;

  lksup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_ref),
    .rst      (sys_rst),
    .async_in (cm_locked),
    .level    (lock_lvl),
    .fell     (lock_fell)
  );

  // Pulse start: system reset, lock loss, or timeout without lock
  always_comb begin
    pulse_load = sys_rst;
    if (state == ST_LOCKED && lock_fell)             pulse_load = 1'b1;
    if (state == ST_WAIT && wait_done && !lock_lvl)  pulse_load = 1'b1;
  end

  assign wait_load = !sys_rst && (state == ST_PULSE) && pulse_done;

  lksup_timer #(.CYCLES(PULSE_CYCLES)) u_pulse (
    .clk  (clk_ref),
    .rst  (1'b0),
    .load (pulse_load),
    .run  (state == ST_PULSE),
    .done (pulse_done)
  );

  lksup_timer #(.CYCLES(TIMEOUT_CYCLES)) u_wait (
    .clk  (clk_ref),
    .rst  (sys_rst),
    .load (wait_load),
    .run  (state == ST_WAIT),
    .done (wait_done)
  );

  always_ff @(posedge clk_ref) begin
    if (sys_rst) begin
      state <= ST_PULSE;
      rst_q <= 1'b1;
    end else begin
      case (state)
        ST_LOCKED: if (lock_fell) begin
          state <= ST_PULSE;
          rst_q <= 1'b1;
        end
        ST_PULSE: if (pulse_done) begin
          state <= ST_WAIT;
          rst_q <= 1'b0;
        end
        ST_WAIT: begin
          if (lock_lvl) begin
            state <= ST_LOCKED;
          end else if (wait_done) begin
            state <= ST_PULSE;
            rst_q <= 1'b1;
          end
        end
        default: begin
          state <= ST_PULSE;
          rst_q <= 1'b1;
        end
      endcase
    end
  end

  assign cm_reset = rst_q;

  // R1: system reset forces the output high at the next edge
  a_r1_sysrst_high: assert property (@(posedge clk_ref)
    sys_rst |=> cm_reset);

  // R3: a lock fall in the locked state starts a pulse
  a_r3_fall_pulse: assert property (@(posedge clk_ref) disable iff (sys_rst)
    (state == ST_LOCKED && lock_fell) |=> cm_reset);

  // R5: timeout without lock issues a retry
  a_r5_timeout_retry: assert property (@(posedge clk_ref) disable iff (sys_rst)
    (state == ST_WAIT && wait_done && !lock_lvl) |=> cm_reset);

  // R6 and R8: lock seen while waiting wins and keeps the output low
  a_r8_lock_wins: assert property (@(posedge clk_ref) disable iff (sys_rst)
    (state == ST_WAIT && lock_lvl) |=> (!cm_reset && state == ST_LOCKED));

  // R7: an unfinished pulse keeps the output high whatever lock does
  a_r7_pulse_holds: assert property (@(posedge clk_ref) disable iff (sys_rst)
    (state == ST_PULSE && !pulse_done) |=> cm_reset);

endmodule

// File: tb/test_lock_supervisor.sv
module test_lock_supervisor;

  localparam int P = 20;
  localparam int T = 12;

  typedef struct {
    logic  lvl;
    int    len;
    string req;
  } run_t;

  logic clk_ref = 1'b0;
  logic sys_rst = 1'b1;
  logic cm_locked = 1'b0;
  logic cm_reset;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  run_t exp_q[$];

  always #2 clk_ref = ~clk_ref;

  lock_supervisor #(
    .PULSE_CYCLES   (P),
    .TIMEOUT_CYCLES (T),
    .SYNC_STAGES    (2)
  ) i_lock_supervisor (
    .clk_ref   (clk_ref),
    .sys_rst   (sys_rst),
    .cm_locked (cm_locked),
    .cm_reset  (cm_reset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic lvl, input int len, input string req);
    run_t r;
    r.lvl = lvl; r.len = len; r.req = req;
    exp_q.push_back(r);
  endtask

  task automatic wait_to(input logic lvl);
    logic prev;
    prev = cm_reset;
    forever begin
      @(negedge clk_ref);
      if (prev !== lvl && cm_reset === lvl) break;
      prev = cm_reset;
    end
  endtask

  // Monitor: measure each run of cm_reset and compare it with the queue
  logic cur_lvl;
  int   run_len = 0;
  always @(negedge clk_ref) begin
    if (run_len == 0) begin
      cur_lvl = cm_reset;
      run_len = 1;
      check(cm_reset === 1'b1, "R1 reset state", int'(cm_reset), 1);
    end else if (cm_reset !== cur_lvl) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected run", run_len, 0);
      end else begin
        run_t e;
        e = exp_q.pop_front();
        check(cur_lvl === e.lvl, {e.req, " level"}, int'(cur_lvl), int'(e.lvl));
        if (e.len != 0)
          check(run_len == e.len, {e.req, " length"}, run_len, e.len);
      end
      cur_lvl = cm_reset;
      run_len = 1;
    end else begin
      run_len++;
    end
  end

  initial begin
    // R1 initial pulse, then unlocked retries (R5, R4)
    push(1'b1, P + 2, "R1");
    push(1'b0, T, "R5");
    push(1'b1, P, "R7");
    push(1'b0, T, "R5");
    push(1'b1, P, "R4");
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref);
    sys_rst = 1'b0;

    // R7: lock pulses high and falls again inside a running pulse
    wait_to(1'b1);
    repeat (3) @(negedge clk_ref);
    cm_locked = 1'b1;
    repeat (5) @(negedge clk_ref);
    cm_locked = 1'b0;

    // R6: lock arrives during a pulse, block settles locked
    wait_to(1'b1);
    repeat (4) @(negedge clk_ref);
    cm_locked = 1'b1;
    push(1'b0, 0, "R6");
    wait_to(1'b0);
    repeat (30) @(negedge clk_ref);
    check(cm_reset === 1'b0, "R6 stays low while locked", int'(cm_reset), 0);

    // R3: lock loss latency through the synchronizer
    push(1'b1, P, "R4");
    cm_locked = 1'b0;
    @(negedge clk_ref);
    check(cm_reset === 1'b0, "R3 edge 1", int'(cm_reset), 0);
    @(negedge clk_ref);
    check(cm_reset === 1'b0, "R3 edge 2", int'(cm_reset), 0);
    @(negedge clk_ref);
    check(cm_reset === 1'b1, "R3 edge 3", int'(cm_reset), 1);

    // R8: lock reaches the synchronizer output in the expiry cycle
    push(1'b0, 0, "R8");
    wait_to(1'b0);
    repeat (T - 3) @(negedge clk_ref);
    cm_locked = 1'b1;
    repeat (T + 4) @(negedge clk_ref);
    check(cm_reset === 1'b0, "R8 lock on expiry wins", int'(cm_reset), 0);

    // R8: lock one cycle too late, retry is issued after exactly T
    push(1'b1, P, "R4");
    push(1'b0, T, "R8");
    push(1'b1, P, "R8");
    push(1'b0, 0, "R6");
    cm_locked = 1'b0;
    wait_to(1'b1);
    wait_to(1'b0);
    repeat (T - 2) @(negedge clk_ref);
    cm_locked = 1'b1;
    wait_to(1'b1);
    wait_to(1'b0);
    repeat (5) @(negedge clk_ref);

    // R1: single-cycle system reset while locked
    push(1'b1, P, "R1");
    push(1'b0, 0, "R6");
    sys_rst = 1'b1;
    @(negedge clk_ref);
    sys_rst = 1'b0;
    wait_to(1'b0);
    repeat (5) @(negedge clk_ref);

    // R2: second system reset six cycles into the pulse
    push(1'b1, P + 6, "R2");
    sys_rst = 1'b1;
    @(negedge clk_ref);
    sys_rst = 1'b0;
    repeat (5) @(negedge clk_ref);
    sys_rst = 1'b1;
    @(negedge clk_ref);
    sys_rst = 1'b0;
    wait_to(1'b0);
    repeat (5) @(negedge clk_ref);

    check(exp_q.size() == 0, "R4 all expected runs seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule